// File: doc/BRIEF.md
# Audio InfoFrame Packet Builder

This block keeps the audio InfoFrame contents for an HDMI-style transmitter and hands the finished packet, one byte per cycle, to the data-island packet scheduler. Software writes five payload bytes and a packet control byte through a simple write port. The header constants come from hardware. The block also fills the reserved payload bytes with zeros, replaces any nonzero channel-allocation code with the 8-channel code, and generates the checksum byte.

When the scheduler pulses a frame request while the serializer is idle and audio packets are enabled, the block takes a snapshot of the payload and checksum. It then streams 14 bytes under a valid/ready handshake. If repeat is clear, the packet goes out once and the enable bit clears itself. If repeat is set, every frame request that finds the serializer idle produces a packet. The AVI enable and repeat bits are held in the same control byte for the neighbouring packet source.

Top module: `audio_infoframe_builder`

## Requirements
- R1: After reset `outValid` is 0 and `ctrlState` reads 0x00.
- R2: Stream bytes 0, 1 and 2 of every packet are 0x84, 0x01 and 0x0A.
- R3: A packet is exactly 14 bytes. Bytes 4..8 are the payload registers at write addresses 0..4, and bytes 9..13 are 0x00. `outFirst` marks byte 0 and `outLast` marks byte 13. `outValid` stays high from byte 0 to the handshake on byte 13 and drops right after it.
- R4: Byte 3 is the checksum. With it, the 8-bit sum of all 14 bytes is zero.
- R5: If the register at address 3 (channel allocation) is nonzero, byte 7 is sent as 0x13 and the checksum covers 0x13. A zero value is sent as 0x00.
- R6: Address 5 is the control byte. Bit 5 is audio enable, bit 4 audio repeat, bit 1 AVI enable and bit 0 AVI repeat. Its value appears on `ctrlState` the cycle after the write, with all other bits reading 0.
- R7: With audio enable set and repeat clear, a frame request starts one packet. Bit 5 of `ctrlState` reads 0 from the cycle after the start, and later requests start nothing.
- R8: With audio enable and repeat both set, each frame request that finds the serializer idle starts a packet, and the control byte is unchanged.
- R9: A frame request is ignored while audio enable is clear or while a packet is in progress.
- R10: While `outValid` is high and `outReady` is low, `outValid`, `outData` and the byte position hold.
- R11: Payload writes made during a packet do not change that packet. The next packet carries the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Write address: 0..4 payload bytes 1..5, 5 control byte |
| regWrData | input | 8 | Write data |
| ctrlState | output | 8 | Current control byte |
| frameReq | input | 1 | Scheduler request pulse for a new packet |
| outValid | output | 1 | Stream byte valid |
| outReady | input | 1 | Scheduler accepts the byte |
| outData | output | 8 | Stream byte |
| outFirst | output | 1 | Marks the first byte of a packet |
| outLast | output | 1 | Marks the last byte of a packet |

## Verification
The hardest cases to reach are the ones where a packet is already in flight while the scheduler is stalling. One is a payload write that lands mid-packet, which must leave the streamed bytes and checksum untouched. The other is a second frame request that must not restart the serializer. The stimulus reaches them by injecting a write or a request at a fixed cycle inside a packet while `outReady` is randomly throttled. Seeded random payloads, including random channel-allocation codes, check the checksum against a bench-side model. The once and repeat modes are then driven in turn.

// File: rtl/aif_pkg.sv
package aif_pkg;
  localparam int BYTE_W    = 8;
  localparam int ADDR_W    = 3;
  localparam int SW_BYTES  = 5;
  localparam int PAY_BYTES = 10;
  localparam int HDR_BYTES = 3;
  localparam int PKT_BYTES = HDR_BYTES + 1 + PAY_BYTES;
  localparam int IDX_W     = $clog2(PKT_BYTES);
  localparam int PAY_START = HDR_BYTES + 1;
  localparam int CA_SLOT   = 3;
  localparam int CTRL_ADDR = SW_BYTES;

  localparam logic [BYTE_W-1:0] HDR_TYPE  = 8'h84;
  localparam logic [BYTE_W-1:0] HDR_VER   = 8'h01;
  localparam logic [BYTE_W-1:0] HDR_LEN   = 8'h0A;
  localparam logic [BYTE_W-1:0] CA_FORCED = 8'h13;

  localparam int AUD_EN_BIT  = 5;
  localparam int AUD_RPT_BIT = 4;
  localparam int AVI_EN_BIT  = 1;
  localparam int AVI_RPT_BIT = 0;
  localparam logic [BYTE_W-1:0] CTRL_MASK =
    BYTE_W'((1 << AUD_EN_BIT) | (1 << AUD_RPT_BIT) | (1 << AVI_EN_BIT) | (1 << AVI_RPT_BIT));

  typedef struct packed {
    logic             latch;
    logic [IDX_W-1:0] idx;
  } seq_strobe_t;
endpackage

// File: rtl/aif_datapath.sv
module aif_datapath
  import aif_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [BYTE_W-1:0] regWrData,
  input  seq_strobe_t       strb,
  output logic [BYTE_W-1:0] byteOut
);
  localparam logic [BYTE_W-1:0] HDR_SUM = HDR_TYPE + HDR_VER + HDR_LEN;
  localparam logic [BYTE_W-1:0] ZERO_CHK = 8'h00 - HDR_SUM;

  logic [BYTE_W-1:0] payReg  [SW_BYTES];
  logic [BYTE_W-1:0] effByte [SW_BYTES];
  logic [BYTE_W-1:0] snap    [SW_BYTES];
  logic [BYTE_W-1:0] liveChk;
  logic [BYTE_W-1:0] snapChk;

  for (genvar g = 0; g < SW_BYTES; g++) begin : g_pay
    always_ff @(posedge clk) begin
      if (!rstN) payReg[g] <= '0;
      else if (regWrEn && regAddr == ADDR_W'(g)) payReg[g] <= regWrData;
    end

    if (g == CA_SLOT) begin : g_ca
      always_comb effByte[g] = (payReg[g] != '0) ? CA_FORCED : payReg[g];
    end else begin : g_plain
      always_comb effByte[g] = payReg[g];
    end

    always_ff @(posedge clk) begin
      if (!rstN) snap[g] <= '0;
      else if (strb.latch) snap[g] <= effByte[g];
    end
  end

  always_comb begin
    logic [BYTE_W-1:0] acc;
    acc = HDR_SUM;
    for (int k = 0; k < SW_BYTES; k++) acc = acc + effByte[k];
    liveChk = 8'h00 - acc;
  end

  always_ff @(posedge clk) begin
    if (!rstN) snapChk <= ZERO_CHK;
    else if (strb.latch) snapChk <= liveChk;
  end

  always_comb begin
    byteOut = '0;
    if (strb.idx == IDX_W'(0)) byteOut = HDR_TYPE;
    else if (strb.idx == IDX_W'(1)) byteOut = HDR_VER;
    else if (strb.idx == IDX_W'(2)) byteOut = HDR_LEN;
    else if (strb.idx == IDX_W'(HDR_BYTES)) byteOut = snapChk;
    for (int k = 0; k < SW_BYTES; k++)
      if (strb.idx == IDX_W'(PAY_START + k)) byteOut = snap[k];
  end

  // Sum of the latched packet, kept apart from the checksum path
  logic [BYTE_W-1:0] snapSum;
  always_comb begin
    snapSum = HDR_SUM + snapChk;
    for (int k = 0; k < SW_BYTES; k++) snapSum = snapSum + snap[k];
  end

  a_r4_sum_zero: assert property (@(posedge clk) disable iff (!rstN)
    snapSum == '0);
  a_r5_ca_coded: assert property (@(posedge clk) disable iff (!rstN)
    (snap[CA_SLOT] == '0) || (snap[CA_SLOT] == CA_FORCED));
  a_r11_snap_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.latch |=> $stable(snapChk));
endmodule

// File: rtl/aif_seq.sv
module aif_seq
  import aif_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [BYTE_W-1:0] regWrData,
  input  logic              frameReq,
  input  logic              outReady,
  output seq_strobe_t       strb,
  output logic              outValid,
  output logic              outFirst,
  output logic              outLast,
  output logic [BYTE_W-1:0] ctrlState
);
  logic [BYTE_W-1:0] ctrlReg;
  logic              busy;
  logic [IDX_W-1:0]  idx;
  logic              ctrlWr, audEn, audRpt, startPkt, xfer, lastIdx;

  assign ctrlWr   = regWrEn && (regAddr == ADDR_W'(CTRL_ADDR));
  assign audEn    = ctrlReg[AUD_EN_BIT];
  assign audRpt   = ctrlReg[AUD_RPT_BIT];
  assign startPkt = frameReq && !busy && audEn;
  assign xfer     = busy && outReady;
  assign lastIdx  = (idx == IDX_W'(PKT_BYTES - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
    end else if (ctrlWr) begin
      ctrlReg <= regWrData & CTRL_MASK;
    end else if (startPkt && !audRpt) begin
      ctrlReg[AUD_EN_BIT] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (startPkt) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (xfer) begin
      if (lastIdx) begin
        busy <= 1'b0;
        idx  <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  always_comb begin
    strb.latch = startPkt;
    strb.idx   = idx;
  end

  assign outValid  = busy;
  assign outFirst  = busy && (idx == '0);
  assign outLast   = busy && lastIdx;
  assign ctrlState = ctrlReg;

  a_r10_stall_hold: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(idx)));
  a_r7_once_clear: assert property (@(posedge clk) disable iff (!rstN)
    (startPkt && !audRpt && !ctrlWr) |=> !ctrlState[AUD_EN_BIT]);
  a_r9_start_gate: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> ($past(frameReq) && $past(audEn)));
  a_r3_drop_after_last: assert property (@(posedge clk) disable iff (!rstN)
    (outLast && outReady) |=> !outValid);
  a_r8_repeat_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (startPkt && audRpt && !ctrlWr) |=> $stable(ctrlState));
endmodule

// File: rtl/audio_infoframe_builder.sv
module audio_infoframe_builder
  import aif_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [BYTE_W-1:0] regWrData,
  output logic [BYTE_W-1:0] ctrlState,
  input  logic              frameReq,
  output logic              outValid,
  input  logic              outReady,
  output logic [BYTE_W-1:0] outData,
  output logic              outFirst,
  output logic              outLast
);
  seq_strobe_t strb;

  aif_seq u_seq (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .frameReq(frameReq), .outReady(outReady),
    .strb(strb), .outValid(outValid), .outFirst(outFirst),
    .outLast(outLast), .ctrlState(ctrlState)
  );

  aif_datapath u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .strb(strb), .byteOut(outData)
  );
endmodule

// File: tb/audio_infoframe_builder_tb.sv
module audio_infoframe_builder_tb;
  logic clk = 0, rstN = 0, regWrEn = 0, frameReq = 0, outReady = 0;
  logic [2:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] ctrlState, outData;
  logic outValid, outFirst, outLast;
  int checks = 0, errors = 0;
  logic [7:0] pm [5];

  always #10 clk = ~clk;

  audio_infoframe_builder u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .ctrlState(ctrlState), .frameReq(frameReq),
    .outValid(outValid), .outReady(outReady), .outData(outData),
    .outFirst(outFirst), .outLast(outLast)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expByte(input int i);
    logic [7:0] e [5];
    logic [7:0] s;
    for (int k = 0; k < 5; k++) e[k] = pm[k];
    if (e[3] != 0) e[3] = 8'h13;
    s = 8'h84 + 8'h01 + 8'h0A;
    for (int k = 0; k < 5; k++) s = s + e[k];
    case (i)
      0: return 8'h84;
      1: return 8'h01;
      2: return 8'h0A;
      3: return 8'h00 - s;
      default: return (i >= 4 && i <= 8) ? e[i-4] : 8'h00;
    endcase
  endfunction

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    regWrEn = 1; regAddr = a; regWrData = d;
    if (a < 5) pm[a] = d;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic pulse();
    frameReq = 1;
    @(negedge clk);
    frameReq = 0;
  endtask

  // mid: 0 none, 1 payload write inside packet, 2 frame request inside packet
  task automatic getPkt(input int rdyPct, input int mid);
    logic [7:0] exp [14];
    logic [7:0] prevD = '0;
    logic prevStall = 0;
    int n = 0, cyc = 0;
    string tag;
    for (int i = 0; i < 14; i++) exp[i] = expByte(i);
    while (n < 14 && cyc < 400) begin
      outReady = ($urandom_range(99) < rdyPct);
      regWrEn = 0; frameReq = 0;
      if (mid == 1 && cyc == 2) begin
        regWrEn = 1; regAddr = 0; regWrData = pm[0] ^ 8'hA5; pm[0] = regWrData;
      end
      if (mid == 2 && cyc == 3) frameReq = 1;
      #5;
      chk("R3 valid held within packet", outValid, 1);
      if (prevStall) chk("R10 data held under stall", outData, prevD);
      if (outValid && outReady) begin
        tag = (n < 3) ? "R2 header" : (n == 3) ? "R4 checksum" :
              (mid == 1) ? "R11 snapshot byte" : (n == 7) ? "R5 channel alloc" : "R3 payload";
        chk(tag, outData, exp[n]);
        chk("R3 first/last flags", {outFirst, outLast}, {n == 0, n == 13});
        n++;
      end
      prevStall = outValid && !outReady;
      prevD = outData;
      @(negedge clk);
      cyc++;
    end
    regWrEn = 0; frameReq = 0; outReady = 0;
    if (n < 14) chk("R3 packet completed", n, 14);
    chk((mid == 2) ? "R9 busy request ignored" : "R3 valid drops after last", outValid, 0);
  endtask

  task automatic idleCheck(input string req, input int cycles);
    for (int i = 0; i < cycles; i++) begin
      #5 chk(req, outValid, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < 5; k++) pm[k] = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    #5;
    chk("R1 reset valid", outValid, 0);
    chk("R1 reset control", ctrlState, 8'h00);
    @(negedge clk);

    pulse();
    idleCheck("R9 request with enable clear", 3);

    for (int k = 0; k < 5; k++) wr(3'(k), 8'(k + 1));
    wr(5, 8'hFF);
    chk("R6 control mask", ctrlState, 8'h33);
    wr(5, 8'h30);
    chk("R6 control value", ctrlState, 8'h30);

    pulse(); getPkt(100, 0);
    wr(3, 8'h00);
    pulse(); getPkt(100, 0);
    wr(3, 8'hFF);
    pulse(); getPkt(40, 0);
    pulse(); getPkt(70, 1);
    pulse(); getPkt(100, 0);
    pulse(); getPkt(60, 2);
    idleCheck("R9 no restart after busy request", 2);
    chk("R8 control kept in repeat", ctrlState, 8'h30);

    for (int it = 0; it < 25; it++) begin
      for (int k = 0; k < 5; k++)
        if ($urandom_range(1)) wr(3'(k), 8'($urandom_range(255)));
      if ($urandom_range(3) == 0) wr(3, 8'h00);
      pulse(); getPkt($urandom_range(100, 30), 0);
      chk("R8 repeat keeps enable", ctrlState, 8'h30);
    end

    wr(5, 8'h22);
    pulse();
    chk("R7 once clears enable", ctrlState, 8'h02);
    getPkt(80, 0);
    pulse();
    idleCheck("R7 no second packet in once mode", 3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule